// File: doc/BRIEF.md
# Misaligned Operand Access Splitter

This block sits between a processor's operand stage and a memory bus that only accepts naturally aligned transfers. The processor hands it one operand at a time: an address, a size (byte, word or longword), a direction and, for stores, the data. When the operand is already aligned, the block passes it through as a single bus transfer. When it is not aligned, the block issues a fixed, short sequence of aligned byte and word transfers that together cover the operand.

Transfers go out in ascending address order and use big-endian byte order. The lowest-addressed piece carries the most significant bytes. Store data is sliced into these pieces. Load data returned by the bus is packed back into a right-justified result.

When the operand finishes, the block pulses a completion strobe. With it come the load result and the number of extra bus cycles that the misalignment cost. Both sides use a valid/ready handshake.

Top module: `opsplit`

## Requirements
- R1: The block holds `req_ready` low from the cycle after it accepts a request until the final transfer of that operand is acknowledged (`bus_valid` and `bus_ready` both high). It then raises `done_valid` for exactly one cycle, in the cycle after that acknowledge, and `req_ready` is high again in that same cycle.
- R2: An aligned operand produces exactly one transfer at the request address with the request size, and reports zero extra cycles. Aligned means: any byte; a word whose address bit 0 is 0; a longword whose address bits 1:0 are 00.
- R3: A word at an odd address produces two byte transfers, at A and A+1.
- R4: A longword whose address bit 0 is 1 produces three transfers: a byte at A, a word at A+1, and a byte at A+3.
- R5: A longword whose address bits 1:0 are 10 produces two word transfers, at A and A+2.
- R6: Size codes are 0 for byte, 1 for word and 2 for longword, on both `req_size` and `bus_size`; a request code of 3 is handled as a longword. Every bus transfer is naturally aligned.
- R7: Store data is taken from the right-justified `req_wdata`. The first transfer carries the most significant bytes. Each transfer's bytes are right-justified in `bus_wdata`, and the unused upper bits are zero.
- R8: For loads, the block takes only the low bytes of `bus_rdata` that match the transfer size and ignores the upper bits. It concatenates these pieces in transfer order, first piece most significant, into a right-justified `done_rdata`.
- R9: `done_extra` is 0 for an aligned operand. For a misaligned operand it is one less than the number of transfers on a store, and equal to the number of transfers on a load. That gives a misaligned word 1 on a store and 2 on a load, a longword at offset 01 or 11 2 and 3, and a longword at offset 10 1 and 2.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_size`, `bus_write` and `bus_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operand request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Operand byte address |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 32 | Right-justified store data |
| bus_valid | output | 1 | Bus transfer present |
| bus_ready | input | 1 | Bus acknowledges transfer |
| bus_addr | output | AW | Transfer address |
| bus_size | output | 2 | Transfer size code |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 32 | Right-justified transfer store data |
| bus_rdata | input | 32 | Right-justified transfer load data, valid with acknowledge |
| done_valid | output | 1 | One-cycle completion strobe |
| done_rdata | output | 32 | Assembled load result |
| done_extra | output | 2 | Extra bus cycles caused by misalignment |

## Verification
The bench tries every combination of operand size, low address offset and direction. Each combination runs under three bus-acknowledge patterns: always ready, ready every other cycle, and ready two cycles out of three.

The offset sweep separates the four transfer plans from one another, and the stalling patterns show whether transfer fields hold and advance only on an acknowledge. The load responses carry nonzero filler above the valid bytes, so masking errors show up. The bench fills memory with distinct byte values, so byte-order or slicing mistakes show up as wrong results.

// File: rtl/opsplit.sv
module opsplit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic          bus_write,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  output logic          done_valid,
  output logic [31:0]   done_rdata,
  output logic [1:0]    done_extra
);
  localparam logic [1:0] SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2;
  localparam logic [1:0] K_ALN = 2'd0, K_WODD = 2'd1, K_LODD = 2'd2, K_LHALF = 2'd3;

  logic          busy, wr, done_q;
  logic [1:0]    kind, idx, opsz, extra_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wsh, acc;

  logic [1:0] in_sz, in_kind, in_base;
  logic [2:0] in_bytes;
  assign in_sz    = req_size[1] ? SZ_L : req_size;
  assign in_bytes = (in_sz == SZ_L) ? 3'd4 : (in_sz == SZ_W) ? 3'd2 : 3'd1;
  assign in_kind  = (in_sz == SZ_W && req_addr[0]) ? K_WODD :
                    (in_sz == SZ_L && req_addr[0]) ? K_LODD :
                    (in_sz == SZ_L && req_addr[1]) ? K_LHALF : K_ALN;
  assign in_base  = (in_kind == K_LODD) ? 2'd2 : 2'd1;

  logic [1:0] ssz;
  logic       last;
  always_comb begin
    case (kind)
      K_ALN:   ssz = opsz;
      K_WODD:  ssz = SZ_B;
      K_LODD:  ssz = (idx == 2'd1) ? SZ_W : SZ_B;
      default: ssz = SZ_W;
    endcase
  end
  assign last = (kind == K_ALN) || ((kind == K_LODD) ? (idx == 2'd2) : (idx == 2'd1));

  logic [2:0]  sbytes;
  logic [5:0]  sbits;
  logic [31:0] rmask;
  logic        go, ack;
  assign sbytes = (ssz == SZ_L) ? 3'd4 : (ssz == SZ_W) ? 3'd2 : 3'd1;
  assign sbits  = {sbytes, 3'b000};
  assign rmask  = ~(32'hFFFF_FFFF << sbits);
  assign go     = req_valid && !busy;
  assign ack    = busy && bus_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done_q  <= 1'b0;
      kind    <= K_ALN;
      idx     <= 2'd0;
      opsz    <= SZ_B;
      wr      <= 1'b0;
      addr_q  <= '0;
      wsh     <= '0;
      acc     <= '0;
      extra_q <= 2'd0;
    end else begin
      done_q <= ack && last;
      if (go) begin
        busy    <= 1'b1;
        kind    <= in_kind;
        idx     <= 2'd0;
        opsz    <= in_sz;
        wr      <= req_write;
        addr_q  <= req_addr;
        wsh     <= req_wdata << (6'd32 - {in_bytes, 3'b000});
        acc     <= '0;
        extra_q <= (in_kind == K_ALN) ? 2'd0 : in_base + {1'b0, ~req_write};
      end else if (ack) begin
        idx    <= idx + 2'd1;
        addr_q <= addr_q + {{(AW-3){1'b0}}, sbytes};
        wsh    <= wsh << sbits;
        if (!wr) acc <= (acc << sbits) | (bus_rdata & rmask);
        if (last) busy <= 1'b0;
      end
    end
  end

  assign req_ready  = !busy;
  assign bus_valid  = busy;
  assign bus_addr   = addr_q;
  assign bus_size   = ssz;
  assign bus_write  = wr;
  assign bus_wdata  = wr ? (wsh >> (6'd32 - sbits)) : 32'd0;
  assign done_valid = done_q;
  assign done_rdata = acc;
  assign done_extra = extra_q;

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> $stable(bus_addr) && $stable(bus_size) &&
                                $stable(bus_write) && $stable(bus_wdata));

  a_r6_natural_align: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_size == SZ_B) || (bus_size == SZ_W && !bus_addr[0]) ||
                  (bus_size == SZ_L && bus_addr[1:0] == 2'b00));

  a_r1_done_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(bus_valid && bus_ready));

  a_r1_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> req_ready && !bus_valid);

  a_r1_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
endmodule

// File: tb/sim_opsplit.sv
module sim_opsplit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, bus_ready = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, bus_rdata = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready, bus_valid, bus_write, done_valid;
  logic [31:0] bus_addr, bus_wdata, done_rdata;
  logic [1:0]  bus_size, done_extra;

  always #4 clk = ~clk;

  opsplit #(.AW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_valid(done_valid), .done_rdata(done_rdata), .done_extra(done_extra));

  int total = 0, bad = 0, cyc = 0, mode = 0;
  logic [7:0] mem [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit stall_now();
    cyc++;
    if (mode == 1) return cyc[0];
    if (mode == 2) return (cyc % 3) == 0;
    return 1'b0;
  endfunction

  task automatic run_op(input logic [31:0] a, input int sz, input bit w, input logic [31:0] wd);
    int n, ns, k, guard;
    int subs[3];
    bit aligned, fin, prev_stall, st;
    string tag;
    logic [31:0] expv, ea, pa, v;
    logic [7:0] expmem [64];
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    aligned = (n == 1) || (n == 2 && !a[0]) || (n == 4 && a[1:0] == 2'b00);
    if (aligned) begin ns = 1; subs[0] = n; tag = "R2"; end
    else if (n == 2) begin ns = 2; subs[0] = 1; subs[1] = 1; tag = "R3"; end
    else if (a[0]) begin ns = 3; subs[0] = 1; subs[1] = 2; subs[2] = 1; tag = "R4"; end
    else begin ns = 2; subs[0] = 2; subs[1] = 2; tag = "R5"; end
    expv = 0;
    for (int i = 0; i < n; i++) expv = (expv << 8) | 32'(mem[(a + i) % 64]);
    for (int i = 0; i < 64; i++) expmem[i] = mem[i];
    if (w) for (int i = 0; i < n; i++) expmem[(a + i) % 64] = 8'(wd >> (8 * (n - 1 - i)));
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_addr = a; req_size = 2'(sz); req_write = w; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; ea = a; fin = 0; prev_stall = 0; pa = 0; guard = 0;
    while (!fin) begin
      bus_ready = 1'b0;
      if (done_valid) begin
        chk(k == ns, tag, "transfer count", 32'(k), 32'(ns));
        chk(done_extra == 2'(aligned ? 0 : (ns - 1 + (w ? 0 : 1))), "R9", "extra cycles",
            32'(done_extra), 32'(aligned ? 0 : (ns - 1 + (w ? 0 : 1))));
        chk(req_ready == 1'b1, "R1", "ready with done", 32'(req_ready), 1);
        if (!w) chk(done_rdata == expv, "R8", "load result", done_rdata, expv);
        else begin
          bit same = 1;
          for (int i = 0; i < 64; i++) if (mem[i] !== expmem[i]) same = 0;
          chk(same, "R7", "memory after store", mem[(a) % 64], expmem[(a) % 64]);
        end
        @(negedge clk);
        chk(done_valid == 1'b0, "R1", "done one cycle", 32'(done_valid), 0);
        fin = 1;
      end else if (bus_valid) begin
        chk(req_ready == 1'b0, "R1", "ready low while busy", 32'(req_ready), 0);
        if (prev_stall) chk(bus_addr == pa, "R10", "address held", bus_addr, pa);
        if (k >= ns) begin
          chk(0, tag, "surplus transfer", 32'(k), 32'(ns));
          fin = 1;
        end else begin
          chk(bus_addr == ea, tag, "transfer address", bus_addr, ea);
          chk(bus_size == 2'(subs[k] == 1 ? 0 : subs[k] == 2 ? 1 : 2), "R6", "transfer size",
              32'(bus_size), 32'(subs[k] == 1 ? 0 : subs[k] == 2 ? 1 : 2));
          chk(bus_write == w, "R6", "transfer direction", 32'(bus_write), 32'(w));
          st = stall_now();
          bus_ready = !st;
          if (!st) begin
            if (w) begin
              if (subs[k] < 4)
                chk((bus_wdata >> (8 * subs[k])) == 0, "R7", "upper store bits", bus_wdata, 0);
              for (int j = 0; j < subs[k]; j++)
                mem[(bus_addr + j) % 64] = 8'(bus_wdata >> (8 * (subs[k] - 1 - j)));
            end else begin
              v = 0;
              for (int j = 0; j < subs[k]; j++) v = (v << 8) | 32'(mem[(bus_addr + j) % 64]);
              bus_rdata = (32'hC3A5_5A3C << (8 * subs[k])) | v;
            end
            ea = ea + 32'(subs[k]);
            k++;
          end
          pa = bus_addr; prev_stall = st;
        end
      end
      if (!fin) @(negedge clk);
      guard++;
      if (guard > 40) begin
        chk(0, tag, "operation hung", 32'(guard), 40);
        fin = 1;
      end
    end
    bus_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 1);
    chk(bus_valid == 1'b0, "R1", "reset bus idle", 32'(bus_valid), 0);
    chk(done_valid == 1'b0, "R1", "reset done idle", 32'(done_valid), 0);
    rst_n = 1'b1;
    for (int m = 0; m < 3; m++) begin
      mode = m;
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
          for (int w = 0; w < 2; w++)
            run_op(32'(8 + 8 * sz + off + 24 * w), sz, w[0],
                   32'h8172_93A4 ^ 32'(m * 5 + sz * 3 + off * 17 + w));
    end
    run_op(32'd22, 3, 1'b0, 32'd0);
    run_op(32'd21, 3, 1'b1, 32'h0BAD_F00D);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule